// File: doc/BRIEF.md
# Supply Fault and Reset Sequencer

This block turns the digital results of four supply-good comparators and two thermal comparators into the reset and shutdown ordering of a motor controller. While any supply is out of range, it holds the chip reset and the register-file clear asserted. The spindle stays off throughout. When a fault hits a running system, the spindle outputs float first. Next the actuator retract is commanded, and only after that does the spindle get a dynamic brake.

The retract ends in one of two ways. The power stage may report completion, or a millisecond timeout may expire first. After every supply has recovered, the reset stays asserted for a fixed power-on delay counted in milliseconds. A supply dip inside that delay starts the count again. A hysteretic over-temperature latch floats the spindle outputs without resetting the chip, and a warning flag follows a separate early-warning comparator.

All comparator inputs are asynchronous and pass through a synchronizer with a configurable number of stages. Each timer divides the system clock into millisecond ticks using its own prescaler.

Top module: `supply_fault_seq`

## Requirements
- R1: When any bit of `supply_ok` is 0, `por_n` goes to 0 and `reg_clear` to 1 exactly SYNC_STAGES+1 clock edges after the input change. Both stay there while the fault lasts.
- R2: If the fault interrupts normal running, `retract_go` and `spin_tristate` are 1 from that same edge on, and `brake_cmd` stays 0 during the retract.
- R3: With `retract_done` sampled 1 during the retract, the next edge sets `brake_cmd` to 1 and clears `retract_go`.
- R4: Without `retract_done`, the brake starts RETRACT_TIMEOUT_MS*CLK_PER_MS+1 edges after the retract began.
- R5: `brake_cmd` and `spin_tristate` are never 1 together, and the brake is held for as long as any supply is still low.
- R6: From reset with all supplies good, `por_n` rises exactly SYNC_STAGES+POR_DELAY_MS*CLK_PER_MS+1 edges after reset release. Recovery from a brake takes one edge longer. `reg_clear` and `spin_tristate` fall on the same edge.
- R7: A supply going low during the power-on delay restarts the delay from zero once the supplies are good again.
- R8: `therm_shutdown` sets when `temp_hi` is 1 and clears only when `temp_lo` is 1; otherwise it holds. Either change shows SYNC_STAGES+1 edges after the input.
- R9: While running, a set `therm_shutdown` drives `spin_tristate` to 1 and leaves `por_n` at 1.
- R10: `therm_warn` follows `temp_warn` with a latency of SYNC_STAGES+1 edges.
- R11: While `rst_n` is 0, `por_n`=0, `reg_clear`=1, `spin_tristate`=1, and `retract_go`, `brake_cmd`, `therm_warn` and `therm_shutdown` are 0.
- R12: When the supplies recover during a brake, the brake drops, the spindle floats and the power-on delay runs. A fault during that delay starts neither a retract nor a brake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok | input | NUM_SUPPLIES | One bit per supply comparator, 1 = in range |
| temp_hi | input | 1 | Die temperature above the shutdown set point |
| temp_lo | input | 1 | Die temperature below the shutdown release point |
| temp_warn | input | 1 | Die temperature above the early-warning point |
| retract_done | input | 1 | Actuator retract reported complete |
| por_n | output | 1 | Chip reset, active low |
| reg_clear | output | 1 | Register-file clear, active high |
| spin_tristate | output | 1 | Float the spindle power outputs |
| retract_go | output | 1 | Command the actuator retract |
| brake_cmd | output | 1 | Command the dynamic spindle brake |
| therm_warn | output | 1 | Thermal warning flag |
| therm_shutdown | output | 1 | Thermal shutdown flag |

## Verification
The bench builds the block with CLK_PER_MS=4, POR_DELAY_MS=5, RETRACT_TIMEOUT_MS=6 and SYNC_STAGES=2. At those values the power-on delay and the retract timeout expire within a few dozen clocks, so each can be checked on both sides of its exact release edge. The same settings bring within reach the restart of the delay after a dip and the one-edge difference between release from reset and release after a brake. Keeping two synchronizer stages means every fault, thermal and warning latency is checked with a real pipeline in front of the sequencer.

// File: rtl/supply_fault_seq_pkg.sv
package supply_fault_seq_pkg;
   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,
      ST_RUN     = 2'd1,
      ST_RETRACT = 2'd2,
      ST_BRAKE   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) begin
                  stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfs_ms_timer.sv
module sfs_ms_timer #(
   parameter int CLK_PER_MS = 20000,
   parameter int LIMIT_MS   = 80
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic done
);
   localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
   localparam int MW = $clog2(LIMIT_MS + 1);

   logic [CW-1:0] cyc_q;
   logic [MW-1:0] ms_q;

   assign done = (ms_q == MW'(LIMIT_MS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q <= '0;
         ms_q  <= '0;
      end else if (clear) begin
         cyc_q <= '0;
         ms_q  <= '0;
      end else if (!done) begin
         if (cyc_q == CW'(CLK_PER_MS - 1)) begin
            cyc_q <= '0;
            ms_q  <= ms_q + 1'b1;
         end else begin
            cyc_q <= cyc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sfs_thermal.sv
module sfs_thermal (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_s,
   input  logic lo_s,
   input  logic warn_s,
   output logic shutdown,
   output logic warn
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shutdown <= 1'b0;
         warn     <= 1'b0;
      end else begin
         warn <= warn_s;
         if (hi_s) begin
            shutdown <= 1'b1;
         end else if (lo_s) begin
            shutdown <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/supply_fault_seq.sv
module supply_fault_seq
   import supply_fault_seq_pkg::*;
#(
   parameter int NUM_SUPPLIES       = 4,
   parameter int CLK_PER_MS         = 20000,
   parameter int POR_DELAY_MS       = 80,
   parameter int RETRACT_TIMEOUT_MS = 640,
   parameter int SYNC_STAGES        = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SUPPLIES-1:0] supply_ok,
   input  logic                    temp_hi,
   input  logic                    temp_lo,
   input  logic                    temp_warn,
   input  logic                    retract_done,
   output logic                    por_n,
   output logic                    reg_clear,
   output logic                    spin_tristate,
   output logic                    retract_go,
   output logic                    brake_cmd,
   output logic                    therm_warn,
   output logic                    therm_shutdown
);
   localparam int SW = NUM_SUPPLIES + 3;

   generate
      if (NUM_SUPPLIES < 1) begin : g_bad_supplies
         $error("NUM_SUPPLIES must be at least 1");
      end
      if (CLK_PER_MS < 1) begin : g_bad_clk
         $error("CLK_PER_MS must be at least 1");
      end
      if (POR_DELAY_MS < 1 || RETRACT_TIMEOUT_MS < 1) begin : g_bad_ms
         $error("millisecond limits must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [SW-1:0] raw_in;
   logic [SW-1:0] sync_in;
   logic          fault_s;
   logic          temp_hi_s;
   logic          temp_lo_s;
   logic          temp_warn_s;

   assign raw_in = {temp_warn, temp_lo, temp_hi, supply_ok};

   sfs_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .d_out (sync_in)
   );

   assign fault_s     = ~&sync_in[NUM_SUPPLIES-1:0];
   assign temp_hi_s   = sync_in[NUM_SUPPLIES];
   assign temp_lo_s   = sync_in[NUM_SUPPLIES+1];
   assign temp_warn_s = sync_in[NUM_SUPPLIES+2];

   seq_state_e state_q;
   seq_state_e state_d;
   logic       por_clear;
   logic       por_done;
   logic       ret_clear;
   logic       ret_done;

   assign por_clear = (state_q != ST_HOLD) | fault_s;
   assign ret_clear = (state_q != ST_RETRACT);

   sfs_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .LIMIT_MS(POR_DELAY_MS)) u_por_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (por_clear),
      .done  (por_done)
   );

   sfs_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .LIMIT_MS(RETRACT_TIMEOUT_MS)) u_ret_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ret_clear),
      .done  (ret_done)
   );

   sfs_thermal u_thermal (
      .clk      (clk),
      .rst_n    (rst_n),
      .hi_s     (temp_hi_s),
      .lo_s     (temp_lo_s),
      .warn_s   (temp_warn_s),
      .shutdown (therm_shutdown),
      .warn     (therm_warn)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HOLD:    if (!fault_s && por_done)     state_d = ST_RUN;
         ST_RUN:     if (fault_s)                  state_d = ST_RETRACT;
         ST_RETRACT: if (retract_done || ret_done) state_d = ST_BRAKE;
         ST_BRAKE:   if (!fault_s)                 state_d = ST_HOLD;
         default:                                  state_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
      end else begin
         state_q <= state_d;
      end
   end

   assign por_n         = (state_q == ST_RUN);
   assign reg_clear     = (state_q != ST_RUN);
   assign retract_go    = (state_q == ST_RETRACT);
   assign brake_cmd     = (state_q == ST_BRAKE);
   assign spin_tristate = (state_q == ST_HOLD) || (state_q == ST_RETRACT) ||
                          ((state_q == ST_RUN) && therm_shutdown);
endmodule

// File: rtl/supply_fault_seq_chk.sv
module supply_fault_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic por_n,
   input logic reg_clear,
   input logic spin_tristate,
   input logic retract_go,
   input logic brake_cmd,
   input logic therm_shutdown,
   input logic fault_s,
   input logic temp_lo_s
);
   assert_fault_resets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fault_s |=> (!por_n && reg_clear));

   assert_retract_floats_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(retract_go) |-> (!por_n && spin_tristate && !brake_cmd));

   assert_brake_after_retract_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brake_cmd) |-> $past(retract_go));

   assert_brake_float_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(brake_cmd && spin_tristate));

   assert_brake_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (brake_cmd && fault_s) |=> brake_cmd);

   assert_release_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_n) |-> !$past(fault_s));

   assert_shutdown_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_shutdown && !temp_lo_s) |=> therm_shutdown);

   assert_shutdown_floats_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_shutdown && por_n) |-> spin_tristate);
endmodule

bind supply_fault_seq supply_fault_seq_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .por_n          (por_n),
   .reg_clear      (reg_clear),
   .spin_tristate  (spin_tristate),
   .retract_go     (retract_go),
   .brake_cmd      (brake_cmd),
   .therm_shutdown (therm_shutdown),
   .fault_s        (fault_s),
   .temp_lo_s      (temp_lo_s)
);

// File: tb/supply_fault_seq_bench.sv
`timescale 1ns/1ps
module supply_fault_seq_bench;
   localparam int NS  = 4;
   localparam int CPM = 4;
   localparam int PD  = 5;
   localparam int RT  = 6;
   localparam int SY  = 2;
   localparam int LAT = SY + 1;
   localparam int POR_CYC = SY + PD * CPM + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] supply_ok = '1;
   logic          temp_hi = 1'b0;
   logic          temp_lo = 1'b0;
   logic          temp_warn = 1'b0;
   logic          retract_done = 1'b0;
   logic          por_n, reg_clear, spin_tristate, retract_go, brake_cmd;
   logic          therm_warn, therm_shutdown;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   supply_fault_seq #(
      .NUM_SUPPLIES(NS), .CLK_PER_MS(CPM), .POR_DELAY_MS(PD),
      .RETRACT_TIMEOUT_MS(RT), .SYNC_STAGES(SY)
   ) u_supply_fault_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .temp_hi(temp_hi),
      .temp_lo(temp_lo), .temp_warn(temp_warn), .retract_done(retract_done),
      .por_n(por_n), .reg_clear(reg_clear), .spin_tristate(spin_tristate),
      .retract_go(retract_go), .brake_cmd(brake_cmd), .therm_warn(therm_warn),
      .therm_shutdown(therm_shutdown)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      step(3);
      chk("R11", "por_n", por_n, 0);
      chk("R11", "reg_clear", reg_clear, 1);
      chk("R11", "spin_tristate", spin_tristate, 1);
      chk("R11", "retract_go", retract_go, 0);
      chk("R11", "brake_cmd", brake_cmd, 0);
      chk("R11", "therm_warn", therm_warn, 0);
      chk("R11", "therm_shutdown", therm_shutdown, 0);
   endtask

   task automatic t_powerup();
      rst_n = 1'b1;
      step(POR_CYC - 1);
      chk("R6", "por_n before delay end", por_n, 0);
      step(1);
      chk("R6", "por_n at delay end", por_n, 1);
      chk("R6", "reg_clear at delay end", reg_clear, 0);
      chk("R6", "spin_tristate at delay end", spin_tristate, 0);
   endtask

   task automatic t_fault_done(input logic [NS-1:0] pattern);
      supply_ok = pattern;
      step(LAT - 1);
      chk("R1", "por_n before latency", por_n, 1);
      step(1);
      chk("R1", "por_n", por_n, 0);
      chk("R1", "reg_clear", reg_clear, 1);
      chk("R2", "retract_go", retract_go, 1);
      chk("R2", "spin_tristate", spin_tristate, 1);
      chk("R2", "brake_cmd", brake_cmd, 0);
      step(5);
      chk("R2", "retract held", retract_go, 1);
      retract_done = 1'b1;
      step(1);
      retract_done = 1'b0;
      chk("R3", "brake_cmd", brake_cmd, 1);
      chk("R3", "retract_go", retract_go, 0);
      chk("R5", "spin_tristate in brake", spin_tristate, 0);
      step(10);
      chk("R5", "brake held", brake_cmd, 1);
      chk("R1", "por_n held", por_n, 0);
   endtask

   task automatic t_recover();
      supply_ok = '1;
      step(LAT);
      chk("R12", "brake dropped", brake_cmd, 0);
      chk("R12", "spin_tristate", spin_tristate, 1);
      chk("R12", "por_n", por_n, 0);
      step(PD * CPM);
      chk("R6", "por_n before recovery delay end", por_n, 0);
      step(1);
      chk("R6", "por_n after recovery delay", por_n, 1);
   endtask

   task automatic t_timeout();
      supply_ok = 4'b0111;
      step(LAT);
      chk("R4", "retract started", retract_go, 1);
      step(RT * CPM);
      chk("R4", "retract before timeout", retract_go, 1);
      chk("R4", "brake before timeout", brake_cmd, 0);
      step(1);
      chk("R4", "brake at timeout", brake_cmd, 1);
      chk("R4", "retract at timeout", retract_go, 0);
   endtask

   task automatic t_restart();
      supply_ok = 4'b1110;
      step(LAT);
      retract_done = 1'b1;
      step(1);
      retract_done = 1'b0;
      supply_ok = '1;
      step(LAT + 10);
      supply_ok = 4'b1101;
      step(LAT + 4);
      chk("R12", "no retract from hold", retract_go, 0);
      chk("R12", "no brake from hold", brake_cmd, 0);
      chk("R7", "por_n during dip", por_n, 0);
      supply_ok = '1;
      step(POR_CYC - 1);
      chk("R7", "por_n before restarted delay end", por_n, 0);
      step(1);
      chk("R7", "por_n after restarted delay", por_n, 1);
   endtask

   task automatic t_thermal();
      temp_hi = 1'b1;
      step(LAT - 1);
      chk("R8", "shutdown before latency", therm_shutdown, 0);
      step(1);
      chk("R8", "shutdown set", therm_shutdown, 1);
      chk("R9", "spindle floats", spin_tristate, 1);
      chk("R9", "por_n stays", por_n, 1);
      temp_hi = 1'b0;
      step(6);
      chk("R8", "shutdown holds", therm_shutdown, 1);
      temp_lo = 1'b1;
      step(LAT);
      temp_lo = 1'b0;
      chk("R8", "shutdown cleared", therm_shutdown, 0);
      chk("R9", "spindle driven", spin_tristate, 0);
      temp_warn = 1'b1;
      step(LAT - 1);
      chk("R10", "warn before latency", therm_warn, 0);
      step(1);
      chk("R10", "warn set", therm_warn, 1);
      temp_warn = 1'b0;
      step(LAT);
      chk("R10", "warn cleared", therm_warn, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_powerup();
      t_fault_done(4'b1011);
      t_recover();
      t_timeout();
      t_recover();
      t_restart();
      t_thermal();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule